// File: doc/BRIEF.md
# Reset and Configuration Sequencer

This block steers a switch device from fundamental reset to normal operation. When the active-low reset input is released, it synchronises the release and captures the strap pins once. The straps give the low-order bits of the SMBus slave address and the EEPROM address, the master bus speed, the operating mode and the reset-halt request. The captured values stay fixed until the next reset.

After the capture, the sequencer decides what has to happen before the device may run. In the load mode it raises a load request to an external EEPROM loader and waits for a done pulse, keeping a record of any failure the loader reports. If the halt strap was captured high, it then waits in a held state. The address outputs stay valid in that state, so the SMBus logic can work while it waits. It leaves the held state when a register write clears the halt control bit. Run-enable is raised last and stays high until the next reset.

Top module: `rstcfg_seq`

## Requirements
- R1: The straps are captured on the first clock edge after the synchronised reset release. Strap changes after that edge do not affect any output until the next reset.
- R2: The slave address output `slv_addr[6:0]` carries SMBus address bits 7..1, with bit 0 of the address byte reserved for read/write. Its layout is {1, 1, slv_strap[3], 0, slv_strap[2], slv_strap[1], slv_strap[0]}.
- R3: The EEPROM address output `mst_addr[6:0]` carries address bits 7..1. Its layout is {1, 0, 1, mst_strap[3:0]}.
- R4: `bus_slow` (1 = 100 kHz, 0 = 400 kHz) equals the captured slow strap. No register write changes it.
- R5: With mode strap 0 and the halt strap low, `run_en` rises on the fourth rising edge that sees `rst_n` high, and `ld_req` stays low.
- R6: With mode strap 1, `ld_req` rises on the fourth rising edge after release and holds until the edge that samples `ld_done` high. During that time `run_en` stays low.
- R7: On the edge that ends a load, `ld_err` takes the value of `ld_fail`. It then holds until reset.
- R8: Mode strap values 2 to 7 set `mode_err` on the fourth edge after release, and the sequence then runs as for mode 0 with no load request. Modes 0 and 1 leave `mode_err` at 0.
- R9: With the halt strap captured high, `run_en` stays low after capture and any load for as long as the halt bit stays set. The address outputs remain valid during this time.
- R10: A register write (`reg_wr` = 1) with `reg_wdata_halt` = 0 clears the halt bit, and `run_en` rises on that edge. A write with `reg_wdata_halt` = 1 has no effect.
- R11: Once high, `run_en` stays high until reset. `ld_done` and `ld_fail` outside a load have no effect on `ld_err`.
- R12: While `rst_n` is low, `run_en`, `ld_req`, `mode_err`, `ld_err`, `bus_slow` and both addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low fundamental reset, asynchronous |
| slv_strap | input | 4 | Slave address straps for address bits 5, 3, 2 and 1 (MSB first) |
| mst_strap | input | 4 | EEPROM address straps for address bits 4..1 |
| mode_strap | input | 3 | Operating mode strap |
| halt_strap | input | 1 | Reset-halt strap |
| slow_strap | input | 1 | Master bus slow-mode strap |
| ld_done | input | 1 | Loader completion pulse |
| ld_fail | input | 1 | Loader failure flag, valid with `ld_done` |
| reg_wr | input | 1 | Write strobe to the halt control bit |
| reg_wdata_halt | input | 1 | Value written to the halt control bit |
| slv_addr | output | 7 | Slave SMBus address bits 7..1 |
| mst_addr | output | 7 | EEPROM SMBus address bits 7..1 |
| bus_slow | output | 1 | 1 selects 100 kHz on the master bus |
| ld_req | output | 1 | Configuration load request |
| run_en | output | 1 | Normal operation enable |
| mode_err | output | 1 | A reserved mode value was captured |
| ld_err | output | 1 | The loader reported a failure |

## Verification
The assertions check four things on every cycle. The captured addresses and speed hold after the capture edge, and their fixed bits keep the required values. Capture happens only once per reset. Run-enable never falls and the load-error flag moves only at the end of a load. The exact edge on which run-enable or the load request rises, the strap-to-address mapping, the decoding of each mode value and the effect of register writes can only be shown by the bench. It does this with random strap sets and with directed writes that either set or clear the halt bit.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

  localparam int ADDR_W   = 7;
  localparam int MODE_RUN = 0;
  localparam int MODE_EEP = 1;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_LOAD   = 3'd2,
    ST_HALT   = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

endpackage

// File: rtl/rstcfg_rsync.sv
module rstcfg_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rstcfg_strap.sv
module rstcfg_strap
  import rstcfg_pkg::*;
#(
  parameter int SLV_W  = 4,
  parameter int MST_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [SLV_W-1:0]  slv_strap,
  input  logic [MST_W-1:0]  mst_strap,
  input  logic [MODE_W-1:0] mode_strap,
  input  logic              slow_strap,
  output logic [ADDR_W-1:0] slv_addr,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [MODE_W-1:0] mode_q,
  output logic              slow_q
);

  // Address byte bits 7..1 map to vector bits 6..0.
  localparam logic [ADDR_W-1:0] SLV_FIXED = 7'b110_0000;
  localparam logic [ADDR_W-1:0] MST_FIXED = 7'b101_0000;

  logic [ADDR_W-1:0] slv_d, mst_d;
  logic [ADDR_W-1:0] slv_q, mst_q;

  always_comb begin
    slv_d      = SLV_FIXED;
    slv_d[2:0] = slv_strap[2:0];
    slv_d[4]   = slv_strap[3];
    mst_d      = MST_FIXED;
    mst_d[3:0] = mst_strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slv_q  <= '0;
      mst_q  <= '0;
      mode_q <= '0;
      slow_q <= 1'b0;
    end else if (cap_en) begin
      slv_q  <= slv_d;
      mst_q  <= mst_d;
      mode_q <= mode_strap;
      slow_q <= slow_strap;
    end
  end

  assign slv_addr = slv_q;
  assign mst_addr = mst_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(slv_q) && $stable(mst_q) && $stable(mode_q))) else $error("addr hold"); // R1
  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(slow_q)) else $error("speed hold"); // R4
  AST_SLV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && $past(cap_en)) |-> (slv_q[6:5] == 2'b11 && slv_q[3] == 1'b0)) else $error("slv fixed"); // R2
  AST_MST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && $past(cap_en)) |-> (mst_q[6:4] == 3'b101)) else $error("mst fixed"); // R3

endmodule

// File: rtl/rstcfg_fsm.sv
module rstcfg_fsm
  import rstcfg_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              halt_strap,
  input  logic              ld_done,
  input  logic              ld_fail,
  input  logic              reg_wr,
  input  logic              reg_wdata_halt,
  output logic              cap_en,
  output logic              ld_req,
  output logic              run_en,
  output logic              mode_err,
  output logic              ld_err
);

  localparam logic [MODE_W-1:0] M_RUN = MODE_W'(MODE_RUN);
  localparam logic [MODE_W-1:0] M_EEP = MODE_W'(MODE_EEP);

  seq_state_e state_q, state_d;
  logic       halt_q, halt_d, halt_en;
  logic       merr_q, merr_en;
  logic       lerr_q, lerr_en;
  logic       halt_clr, load_end, halt_hold;

  assign halt_clr  = reg_wr && !reg_wdata_halt;
  assign load_end  = (state_q == ST_LOAD) && ld_done;
  assign halt_hold = halt_q && !halt_clr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (mode_q == M_EEP)  state_d = ST_LOAD;
        else if (halt_hold)   state_d = ST_HALT;
        else                  state_d = ST_RUN;
      end
      ST_LOAD: begin
        if (ld_done) state_d = halt_hold ? ST_HALT : ST_RUN;
      end
      ST_HALT: begin
        if (!halt_hold) state_d = ST_RUN;
      end
      ST_RUN:  state_d = ST_RUN;
      default: state_d = ST_RESET;
    endcase
  end

  always_comb begin
    halt_en = cap_en || halt_clr;
    halt_d  = cap_en ? halt_strap : 1'b0;
    merr_en = (state_q == ST_SAMPLE);
    lerr_en = load_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      merr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      if (halt_en) halt_q <= halt_d;
      if (merr_en) merr_q <= (mode_q != M_RUN) && (mode_q != M_EEP);
      if (lerr_en) lerr_q <= ld_fail;
    end
  end

  assign cap_en   = (state_q == ST_RESET);
  assign ld_req   = (state_q == ST_LOAD);
  assign run_en   = (state_q == ST_RUN);
  assign mode_err = merr_q;
  assign ld_err   = lerr_q;

  AST_CAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !cap_en) else $error("capture repeated"); // R1
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> run_en) else $error("run dropped"); // R11
  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_done) |=> (ld_req && !run_en)) else $error("load left early"); // R6
  AST_LERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_req && ld_done) |=> $stable(ld_err)) else $error("ld_err moved"); // R7
  AST_HALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && !halt_clr) |=> !run_en) else $error("halt left"); // R9

endmodule

// File: rtl/rstcfg_seq.sv
module rstcfg_seq
  import rstcfg_pkg::*;
#(
  parameter int SLV_W       = 4,
  parameter int MST_W       = 4,
  parameter int MODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLV_W-1:0]  slv_strap,
  input  logic [MST_W-1:0]  mst_strap,
  input  logic [MODE_W-1:0] mode_strap,
  input  logic              halt_strap,
  input  logic              slow_strap,
  input  logic              ld_done,
  input  logic              ld_fail,
  input  logic              reg_wr,
  input  logic              reg_wdata_halt,
  output logic [ADDR_W-1:0] slv_addr,
  output logic [ADDR_W-1:0] mst_addr,
  output logic              bus_slow,
  output logic              ld_req,
  output logic              run_en,
  output logic              mode_err,
  output logic              ld_err
);

  logic              rst_s_n;
  logic              cap_en;
  logic [MODE_W-1:0] mode_q;

  rstcfg_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rstcfg_strap #(.SLV_W(SLV_W), .MST_W(MST_W), .MODE_W(MODE_W)) u_strap (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cap_en     (cap_en),
    .slv_strap  (slv_strap),
    .mst_strap  (mst_strap),
    .mode_strap (mode_strap),
    .slow_strap (slow_strap),
    .slv_addr   (slv_addr),
    .mst_addr   (mst_addr),
    .mode_q     (mode_q),
    .slow_q     (bus_slow)
  );

  rstcfg_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_s_n),
    .mode_q         (mode_q),
    .halt_strap     (halt_strap),
    .ld_done        (ld_done),
    .ld_fail        (ld_fail),
    .reg_wr         (reg_wr),
    .reg_wdata_halt (reg_wdata_halt),
    .cap_en         (cap_en),
    .ld_req         (ld_req),
    .run_en         (run_en),
    .mode_err       (mode_err),
    .ld_err         (ld_err)
  );

endmodule

// File: tb/rstcfg_seq_bench.sv
`timescale 1ns/1ps
module rstcfg_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] slv_strap = '0, mst_strap = '0;
  logic [2:0] mode_strap = '0;
  logic       halt_strap = 1'b0, slow_strap = 1'b0;
  logic       ld_done = 1'b0, ld_fail = 1'b0, reg_wr = 1'b0, reg_wdata_halt = 1'b0;
  logic [6:0] slv_addr, mst_addr;
  logic       bus_slow, ld_req, run_en, mode_err, ld_err;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rstcfg_seq u_rstcfg_seq (
    .clk(clk), .rst_n(rst_n), .slv_strap(slv_strap), .mst_strap(mst_strap),
    .mode_strap(mode_strap), .halt_strap(halt_strap), .slow_strap(slow_strap),
    .ld_done(ld_done), .ld_fail(ld_fail), .reg_wr(reg_wr), .reg_wdata_halt(reg_wdata_halt),
    .slv_addr(slv_addr), .mst_addr(mst_addr), .bus_slow(bus_slow), .ld_req(ld_req),
    .run_en(run_en), .mode_err(mode_err), .ld_err(ld_err)
  );

  function automatic logic [6:0] exp_slv(input logic [3:0] s);
    return {2'b11, s[3], 1'b0, s[2:0]};
  endfunction

  function automatic logic [6:0] exp_mst(input logic [3:0] m);
    return {3'b101, m};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One full sequence from reset to run; directed values passed in.
  task automatic run_seq(input logic [3:0] s, input logic [3:0] m, input logic [2:0] md,
                         input bit hlt, input bit slw, input bit fail, input int wait_cyc);
    logic [6:0] es, em;
    bit         load, merr;
    es   = exp_slv(s);
    em   = exp_mst(m);
    load = (md == 3'd1);
    merr = (md > 3'd1);
    @(negedge clk);
    rst_n = 1'b0;
    slv_strap = s; mst_strap = m; mode_strap = md; halt_strap = hlt; slow_strap = slw;
    tick(2);
    chk(run_en == 0 && ld_req == 0 && mode_err == 0 && ld_err == 0 && slv_addr == 0 &&
        mst_addr == 0 && bus_slow == 0, "R12 reset state",
        {run_en, ld_req, mode_err, ld_err, bus_slow}, 0);
    rst_n = 1'b1;
    tick(3);  // edges E0, E1 (sync), E2 (capture)
    chk(run_en == 0 && ld_req == 0, "R5 no run before fourth edge", {run_en, ld_req}, 0);
    // Scramble straps after capture: must not matter (R1).
    slv_strap = ~s; mst_strap = ~m; mode_strap = md ^ 3'd3; halt_strap = ~hlt; slow_strap = ~slw;
    tick(1);  // E3
    chk(slv_addr == es, "R2 slave address", slv_addr, es);
    chk(mst_addr == em, "R3 master address", mst_addr, em);
    chk(bus_slow == slw, "R4 bus speed", bus_slow, slw);
    chk(mode_err == merr, "R8 mode error flag", mode_err, merr);
    chk(ld_req == load, "R6 load request", ld_req, load);
    chk(run_en == (!load && !hlt), "R5 run on fourth edge", run_en, (!load && !hlt));
    if (load) begin
      tick(wait_cyc);
      chk(ld_req == 1 && run_en == 0, "R6 load held until done", {ld_req, run_en}, 2);
      ld_done = 1'b1; ld_fail = fail;
      tick(1);
      ld_done = 1'b0; ld_fail = 1'b0;
      chk(ld_req == 0, "R6 load ends on done", ld_req, 0);
      chk(ld_err == fail, "R7 load error captured", ld_err, fail);
      chk(run_en == !hlt, "R6 run after load", run_en, !hlt);
    end
    if (hlt) begin
      tick(wait_cyc);
      chk(run_en == 0 && slv_addr == es && mst_addr == em, "R9 halted with valid addresses",
          run_en, 0);
      reg_wr = 1'b1; reg_wdata_halt = 1'b1;
      tick(1);
      reg_wr = 1'b0;
      chk(run_en == 0, "R10 write of one has no effect", run_en, 0);
      reg_wr = 1'b1; reg_wdata_halt = 1'b0;
      tick(1);
      reg_wr = 1'b0;
      chk(run_en == 1, "R10 clearing halt bit starts run", run_en, 1);
    end
    // Stray loader pulse in RUN must not touch ld_err, run stays (R11); writes leave speed (R4).
    ld_done = 1'b1; ld_fail = ~(load & fail); reg_wr = 1'b1; reg_wdata_halt = 1'b0;
    tick(1);
    ld_done = 1'b0; ld_fail = 1'b0; reg_wr = 1'b0;
    tick(1);
    chk(ld_err == (load & fail), "R11 stray done ignored", ld_err, (load & fail));
    chk(run_en == 1, "R11 run stays high", run_en, 1);
    chk(bus_slow == slw && slv_addr == es, "R4 speed unchanged by write", bus_slow, slw);
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    // Directed corners.
    run_seq(4'h0, 4'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1);
    run_seq(4'hF, 4'hF, 3'd1, 1'b0, 1'b1, 1'b1, 0);
    run_seq(4'h5, 4'hA, 3'd1, 1'b1, 1'b0, 1'b0, 3);
    run_seq(4'hA, 4'h5, 3'd7, 1'b1, 1'b1, 1'b0, 5);
    run_seq(4'h8, 4'h1, 3'd2, 1'b0, 1'b0, 1'b0, 2);
    // Random sets.
    for (int k = 0; k < 40; k++) begin
      logic [2:0] md;
      md = 3'($urandom_range(0, 7));
      if (k % 3 == 0) md = 3'd1;
      run_seq(4'($urandom), 4'($urandom), md, 1'($urandom), 1'($urandom), 1'($urandom),
              int'($urandom_range(0, 8)));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule